// File: doc/BRIEF.md
# Boot-Mode Address Decoder with Remap

This block turns every processor address into a route. It sends the address to the primary internal SRAM, the extended internal SRAM, external chip select 0, the other external chip selects or the internal peripherals. It also flags an abort for external addresses that no device claims. The 4 GB space has three parts. The bottom 4 MB holds internal memory, the top 4 MB holds peripherals, and all addresses in between belong to the external bus.

What answers at address zero depends on two things. The first is a boot strap pin, sampled while reset is held low. The second is a remap bit that software sets through a one-bit register write port. Setting the remap bit moves the primary SRAM to address zero, which lets software rewrite the exception vectors. The same bit also opens chip selects 1 to 7. Only the reset input clears it again.

Each select also comes with the byte offset of the access inside the selected device, so address aliasing can be seen at the ports.

Top module: `bootmap_decoder`

## Requirements
- R1: While `addr_valid` is low, all selects, `bus_abort` and `dev_offset` are zero.
- R2: At most one of the five selects and `bus_abort` is high in any cycle.
- R3: The level of `boot_pin` at the last clock edge with `rst_n` low picks the boot device, even if the pin held another level earlier in the reset. A 1 picks the extended SRAM and a 0 picks chip select 0. Before remap, that device answers the window 0x0000_0000–0x000F_FFFF with offset = address modulo its size.
- R4: A write with `cfg_we` high and `cfg_wdata` bit 0 set turns remap on from the next cycle. While remap is on, the window at zero selects the primary SRAM, with offset = address modulo 8 KB.
- R5: Remap stays on when zero is written or when further writes arrive. Only a cycle with `rst_n` low clears it.
- R6: Addresses 0x0010_0000–0x0011_FFFF select the extended SRAM whether or not remap is on. The offset is the address minus the base.
- R7: Addresses 0xFFC0_0000–0xFFFF_FFFF select the peripherals and never abort. The offset is the address minus 0xFFC0_0000.
- R8: Internal addresses 0x0012_0000–0x003F_FFFF select nothing and do not abort.
- R9: Addresses 0x0040_0000–0x004F_FFFF select chip select 0 at any time. The offset is the address modulo 1 MB.
- R10: Addresses 0x0050_0000–0x00BF_FFFF (chip selects 1 to 7, 1 MB each) assert `sel_ext` only while remap is on, with offset = address modulo 1 MB. Before remap they abort.
- R11: External addresses 0x00C0_0000–0xFFBF_FFFF abort.
- R12: Changes on `boot_pin` while `rst_n` is high do not change the boot device.

Each of R3 to R11 applies only while `addr_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously |
| boot_pin | input | 1 | Boot strap level, sampled during reset |
| addr | input | 32 | Processor byte address |
| addr_valid | input | 1 | Access strobe |
| cfg_we | input | 1 | Remap register write enable |
| cfg_wdata | input | 32 | Remap register write data, bit 0 is the remap bit |
| sel_pram | output | 1 | Primary SRAM select |
| sel_xram | output | 1 | Extended SRAM select |
| sel_cs0 | output | 1 | External chip select 0 |
| sel_ext | output | 1 | External chip selects 1 to 7 |
| sel_periph | output | 1 | Internal peripheral select |
| bus_abort | output | 1 | Undefined external address |
| dev_offset | output | 32 | Byte offset inside the selected device |

## Verification
The hardest case to reach is a boot strap that changes inside the reset window. The decode must follow the level on the final reset edge, not the level the pin held for most of the reset. The stimulus holds the pin at 1 for nine reset cycles and then drops it to 0 for the last one. It then checks that address zero reaches chip select 0. The bench also toggles the pin after reset, and writes zero to the remap register before and after the real remap write. This shows that neither action moves the map.

// File: rtl/bootmap_pkg.sv
package bootmap_pkg;

    typedef struct packed {
        logic boot_xram;
        logic remapped;
    } map_state_t;

    typedef struct packed {
        logic pram;
        logic xram;
        logic cs0;
        logic ext;
        logic periph;
        logic abort_f;
    } route_t;

endpackage

// File: rtl/bootmap_state.sv
module bootmap_state
    import bootmap_pkg::*;
#(
    parameter int CFG_W     = 32,
    parameter int REMAP_BIT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boot_pin,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output map_state_t       st_q
);

    map_state_t st_d;

    // During reset the strap is re-sampled on every edge, so the final
    // reset edge decides; remap is forced off.
    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.boot_xram = boot_pin;
            st_d.remapped  = 1'b0;
        end else if (cfg_we && cfg_wdata[REMAP_BIT]) begin
            st_d.remapped  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

endmodule

// File: rtl/bootmap_bank_match.sv
module bootmap_bank_match #(
    parameter int                ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] EXT_BASE = 32'h0040_0000,
    parameter logic [ADDR_W-1:0] CS_BYTES = 32'h0010_0000,
    parameter int                NUM_CS   = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CS-1:0] hit
);

    for (genvar k = 0; k < NUM_CS; k++) begin : g_bank
        localparam logic [ADDR_W-1:0] BASE = EXT_BASE + ADDR_W'(k) * CS_BYTES;
        localparam logic [ADDR_W-1:0] LAST = BASE + CS_BYTES - ADDR_W'(1);
        assign hit[k] = (addr >= BASE) && (addr <= LAST);
    end

endmodule

// File: rtl/bootmap_decode.sv
module bootmap_decode
    import bootmap_pkg::*;
#(
    parameter int                ADDR_W       = 32,
    parameter int                REGION_SHIFT = 22,
    parameter logic [ADDR_W-1:0] BOOT_WIN     = 32'h0010_0000,
    parameter logic [ADDR_W-1:0] PRAM_BYTES   = 32'h0000_2000,
    parameter logic [ADDR_W-1:0] XRAM_BASE    = 32'h0010_0000,
    parameter logic [ADDR_W-1:0] XRAM_BYTES   = 32'h0002_0000,
    parameter logic [ADDR_W-1:0] CS_BYTES     = 32'h0010_0000,
    parameter int                NUM_CS       = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_valid,
    input  map_state_t        st,
    input  logic [NUM_CS-1:0] bank_hit,
    output route_t            route,
    output logic [ADDR_W-1:0] offset
);

    localparam int                HI_W      = ADDR_W - REGION_SHIFT;
    localparam logic [ADDR_W-1:0] PRAM_MASK = PRAM_BYTES - ADDR_W'(1);
    localparam logic [ADDR_W-1:0] XRAM_MASK = XRAM_BYTES - ADDR_W'(1);
    localparam logic [ADDR_W-1:0] CS_MASK   = CS_BYTES - ADDR_W'(1);
    localparam logic [ADDR_W-1:0] PER_MASK  = ADDR_W'((64'd1 << REGION_SHIFT) - 64'd1);
    localparam logic [ADDR_W-1:0] XRAM_LAST = XRAM_BASE + XRAM_MASK;

    logic [HI_W-1:0] region_hi;
    logic            in_int;
    logic            in_per;
    logic            in_boot;
    logic            in_xram;
    logic            hit_upper;

    assign region_hi = addr[ADDR_W-1:REGION_SHIFT];
    assign in_int    = (region_hi == '0);
    assign in_per    = (region_hi == '1);
    assign in_boot   = (addr < BOOT_WIN);
    assign in_xram   = (addr >= XRAM_BASE) && (addr <= XRAM_LAST);
    assign hit_upper = |bank_hit[NUM_CS-1:1];

    always_comb begin
        route  = '0;
        offset = '0;
        if (addr_valid) begin
            if (in_per) begin
                route.periph = 1'b1;
                offset       = addr & PER_MASK;
            end else if (in_int) begin
                if (in_boot) begin
                    if (st.remapped) begin
                        route.pram = 1'b1;
                        offset     = addr & PRAM_MASK;
                    end else if (st.boot_xram) begin
                        route.xram = 1'b1;
                        offset     = addr & XRAM_MASK;
                    end else begin
                        route.cs0  = 1'b1;
                        offset     = addr & CS_MASK;
                    end
                end else if (in_xram) begin
                    route.xram = 1'b1;
                    offset     = addr & XRAM_MASK;
                end
            end else if (bank_hit[0]) begin
                route.cs0 = 1'b1;
                offset    = addr & CS_MASK;
            end else if (hit_upper && st.remapped) begin
                route.ext = 1'b1;
                offset    = addr & CS_MASK;
            end else begin
                route.abort_f = 1'b1;
            end
        end
    end

endmodule

// File: rtl/bootmap_decoder.sv
module bootmap_decoder
    import bootmap_pkg::*;
#(
    parameter int                ADDR_W       = 32,
    parameter int                CFG_W        = 32,
    parameter int                REMAP_BIT    = 0,
    parameter int                REGION_SHIFT = 22,
    parameter logic [ADDR_W-1:0] BOOT_WIN     = 32'h0010_0000,
    parameter logic [ADDR_W-1:0] PRAM_BYTES   = 32'h0000_2000,
    parameter logic [ADDR_W-1:0] XRAM_BASE    = 32'h0010_0000,
    parameter logic [ADDR_W-1:0] XRAM_BYTES   = 32'h0002_0000,
    parameter logic [ADDR_W-1:0] EXT_BASE     = 32'h0040_0000,
    parameter logic [ADDR_W-1:0] CS_BYTES     = 32'h0010_0000,
    parameter int                NUM_CS       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_pin,
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_valid,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic              sel_pram,
    output logic              sel_xram,
    output logic              sel_cs0,
    output logic              sel_ext,
    output logic              sel_periph,
    output logic              bus_abort,
    output logic [ADDR_W-1:0] dev_offset
);

    map_state_t        st_q;
    logic [NUM_CS-1:0] bank_hit;
    route_t            route;

    bootmap_state #(
        .CFG_W    (CFG_W),
        .REMAP_BIT(REMAP_BIT)
    ) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .boot_pin (boot_pin),
        .cfg_we   (cfg_we),
        .cfg_wdata(cfg_wdata),
        .st_q     (st_q)
    );

    bootmap_bank_match #(
        .ADDR_W  (ADDR_W),
        .EXT_BASE(EXT_BASE),
        .CS_BYTES(CS_BYTES),
        .NUM_CS  (NUM_CS)
    ) u_banks (
        .addr(addr),
        .hit (bank_hit)
    );

    bootmap_decode #(
        .ADDR_W      (ADDR_W),
        .REGION_SHIFT(REGION_SHIFT),
        .BOOT_WIN    (BOOT_WIN),
        .PRAM_BYTES  (PRAM_BYTES),
        .XRAM_BASE   (XRAM_BASE),
        .XRAM_BYTES  (XRAM_BYTES),
        .CS_BYTES    (CS_BYTES),
        .NUM_CS      (NUM_CS)
    ) u_decode (
        .addr      (addr),
        .addr_valid(addr_valid),
        .st        (st_q),
        .bank_hit  (bank_hit),
        .route     (route),
        .offset    (dev_offset)
    );

    assign sel_pram   = route.pram;
    assign sel_xram   = route.xram;
    assign sel_cs0    = route.cs0;
    assign sel_ext    = route.ext;
    assign sel_periph = route.periph;
    assign bus_abort  = route.abort_f;

endmodule

// File: rtl/bootmap_decoder_chk.sv
module bootmap_decoder_chk
    import bootmap_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int CFG_W        = 32,
    parameter int REMAP_BIT    = 0,
    parameter int REGION_SHIFT = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              addr_valid,
    input logic              cfg_we,
    input logic [CFG_W-1:0]  cfg_wdata,
    input logic              sel_pram,
    input logic              sel_xram,
    input logic              sel_cs0,
    input logic              sel_ext,
    input logic              sel_periph,
    input logic              bus_abort,
    input logic [ADDR_W-1:0] dev_offset,
    input map_state_t        state_q
);

    logic [5:0] outs;
    assign outs = {sel_pram, sel_xram, sel_cs0, sel_ext, sel_periph, bus_abort};

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |-> (outs == '0) && (dev_offset == '0));

    p_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(outs));

    p_remap_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_wdata[REMAP_BIT] |=> state_q.remapped);

    p_remap_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.remapped |=> state_q.remapped);

    p_periph_r7: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && (&addr[ADDR_W-1:REGION_SHIFT]) |-> sel_periph);

    p_int_no_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && (addr[ADDR_W-1:REGION_SHIFT] == '0) |-> !bus_abort);

    p_gated_ext_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !state_q.remapped |-> !sel_ext);

    p_boot_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(state_q.boot_xram));

endmodule

bind bootmap_decoder bootmap_decoder_chk #(
    .ADDR_W      (ADDR_W),
    .CFG_W       (CFG_W),
    .REMAP_BIT   (REMAP_BIT),
    .REGION_SHIFT(REGION_SHIFT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .addr_valid(addr_valid),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .sel_pram  (sel_pram),
    .sel_xram  (sel_xram),
    .sel_cs0   (sel_cs0),
    .sel_ext   (sel_ext),
    .sel_periph(sel_periph),
    .bus_abort (bus_abort),
    .dev_offset(dev_offset),
    .state_q   (st_q)
);

// File: tb/bootmap_decoder_test.sv
module bootmap_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_pin = 1'b0;
    logic [31:0] addr = '0;
    logic        addr_valid = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        sel_pram, sel_xram, sel_cs0, sel_ext, sel_periph, bus_abort;
    logic [31:0] dev_offset;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // Expected route packing: {pram, xram, cs0, ext, periph, abort}
    localparam logic [5:0] E_NONE = 6'b000000;
    localparam logic [5:0] E_PRAM = 6'b100000;
    localparam logic [5:0] E_XRAM = 6'b010000;
    localparam logic [5:0] E_CS0  = 6'b001000;
    localparam logic [5:0] E_EXT  = 6'b000100;
    localparam logic [5:0] E_PER  = 6'b000010;
    localparam logic [5:0] E_ABT  = 6'b000001;

    always #5 clk = ~clk;

    bootmap_decoder uut (
        .clk(clk), .rst_n(rst_n), .boot_pin(boot_pin),
        .addr(addr), .addr_valid(addr_valid),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .sel_pram(sel_pram), .sel_xram(sel_xram), .sel_cs0(sel_cs0),
        .sel_ext(sel_ext), .sel_periph(sel_periph), .bus_abort(bus_abort),
        .dev_offset(dev_offset)
    );

    task automatic probe(input logic [31:0] a, input logic v,
                         input logic [5:0] exp_r, input logic [31:0] exp_o,
                         input string req);
        logic [5:0] got;
        @(negedge clk);
        addr = a;
        addr_valid = v;
        #2;
        got = {sel_pram, sel_xram, sel_cs0, sel_ext, sel_periph, bus_abort};
        checks++;
        if (got !== exp_r || dev_offset !== exp_o) begin
            failures++;
            $display("FAIL %s addr=%h route=%b offset=%h expected route=%b offset=%h",
                     req, a, got, dev_offset, exp_r, exp_o);
        end
        addr_valid = 1'b0;
    endtask

    task automatic apply_reset(input logic early, input logic last);
        @(negedge clk);
        rst_n = 1'b0;
        addr_valid = 1'b0;
        cfg_we = 1'b0;
        boot_pin = early;
        repeat (9) @(negedge clk);
        boot_pin = last;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cfg_write(input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_wdata = '0;
    endtask

    task automatic t_reset_state;
        apply_reset(1'b0, 1'b1);
        probe(32'h0000_0000, 1'b0, E_NONE, 32'h0, "R1");
        probe(32'hFFC0_0000, 1'b0, E_NONE, 32'h0, "R1");
        probe(32'h0000_0040, 1'b1, E_XRAM, 32'h40, "R3");
    endtask

    task automatic t_fixed_map;
        probe(32'h0010_0010, 1'b1, E_XRAM, 32'h10, "R6");
        probe(32'h0011_FFFF, 1'b1, E_XRAM, 32'h1FFFF, "R6");
        probe(32'h0012_0000, 1'b1, E_NONE, 32'h0, "R8");
        probe(32'h0030_0000, 1'b1, E_NONE, 32'h0, "R8");
        probe(32'hFFC0_0100, 1'b1, E_PER, 32'h100, "R7");
        probe(32'hFFFF_FFFC, 1'b1, E_PER, 32'h3FFFFC, "R7");
        probe(32'h0040_0004, 1'b1, E_CS0, 32'h4, "R9");
        probe(32'h0050_0000, 1'b1, E_ABT, 32'h0, "R10");
        probe(32'h00C0_0000, 1'b1, E_ABT, 32'h0, "R11");
        probe(32'h8000_0000, 1'b1, E_ABT, 32'h0, "R11");
        probe(32'hFFBF_FFFF, 1'b1, E_ABT, 32'h0, "R11");
    endtask

    task automatic t_pin_ignored;
        @(negedge clk) boot_pin = 1'b0;
        repeat (3) @(negedge clk);
        probe(32'h0000_0008, 1'b1, E_XRAM, 32'h8, "R12");
        boot_pin = 1'b1;
    endtask

    task automatic t_remap;
        cfg_write(32'h0000_0000);
        probe(32'h0000_0000, 1'b1, E_XRAM, 32'h0, "R5");
        cfg_write(32'h0000_0001);
        probe(32'h0000_2010, 1'b1, E_PRAM, 32'h10, "R4");
        probe(32'h000F_FFFC, 1'b1, E_PRAM, 32'h1FFC, "R4");
        probe(32'h0050_0008, 1'b1, E_EXT, 32'h8, "R10");
        probe(32'h00BF_FFFF, 1'b1, E_EXT, 32'hFFFFF, "R10");
        cfg_write(32'h0000_0000);
        probe(32'h0000_0004, 1'b1, E_PRAM, 32'h4, "R5");
        probe(32'h0010_0020, 1'b1, E_XRAM, 32'h20, "R6");
        probe(32'h0040_0000, 1'b1, E_CS0, 32'h0, "R9");
    endtask

    task automatic t_boot_cs0;
        apply_reset(1'b1, 1'b0);
        probe(32'h0000_0000, 1'b1, E_CS0, 32'h0, "R3");
        probe(32'h0000_1234, 1'b1, E_CS0, 32'h1234, "R3");
        probe(32'h0050_0000, 1'b1, E_ABT, 32'h0, "R5");
    endtask

    initial begin
        t_reset_state();
        t_fixed_map();
        t_pin_ignored();
        t_remap();
        t_boot_cs0();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule